// File: doc/BRIEF.md
# RTC Interrupt Emulation Engine

This block rebuilds the three classic real-time-clock interrupt sources (once-per-second update, time-of-day alarm and a programmable periodic rate) from a single comparator tick of a free-running counter. The tick arrives at a base rate of 64 per second. Update and alarm events are found by looking at the time-of-day inputs on each tick. The periodic event comes from a divided tick count or, above 64 Hz, from a shorter comparator step.

On each tick the engine moves its comparator value ahead of the main counter. The catch-up is bounded and happens in a single cycle. Every extra step it needs is a lost interrupt. Lost interrupts feed the periodic divider and a saturating loss total. The engine also runs the timer channel's enable: it arms the comparator when the first source is enabled, and drops the channel on a tick where no source is enabled.

The events are reported as a one-cycle interrupt strobe and a flag word. The flag word collects events until it is acknowledged.

Top module: `rtc_irq_emu`

## Requirements
- R1: After reset, `irq_o` is 0, `flags_o` is 0, `chan_en_o` is 0, `cmp_o` is 0 and `lost_o` is 0.
- R2: When the channel is off and at least one of the three enables is set, the next cycle has `chan_en_o`=1 and `cmp_o` = `count_i` + step. The step is BASE_STEP, or BASE_STEP·64/2^code when the periodic enable is set and the clamped rate code is above 6. Arming clears the periodic divider count.
- R3: A tick with the channel on and any enable set advances `cmp_o` by k steps. k is the smallest value in 1..MAX_CATCH for which `count_i` − (`cmp_o` + k·step), read as a signed COUNT_W-bit value, is not positive. If no such value exists, k = MAX_CATCH. The tick loses k−1 interrupts.
- R4: Update flag (bit 4) is set on a tick, with the update enable set, whose seconds input differs from the recorded second. The first tick after the update enable rises only records the second and sets no flag.
- R5: Alarm flag (bit 5) is set on a tick with the alarm enable set when the hours, minutes and seconds inputs all equal the alarm inputs.
- R6: Periodic flag (bit 6): on a tick with the periodic enable set, the divider count grows by 1 plus the lost interrupts. The flag fires and the count returns to 0 once the count reaches the limit. The limit is 64/2^code for codes up to 6 and 1 above. Rate code 0 acts as 1, and codes 14 and 15 act as 13.
- R7: An event sets bit 7 (pending) and puts the count 1 in bits 15:8 of `flags_o`. `irq_o` pulses for one cycle, one cycle after the tick. A tick with no event leaves `irq_o` low and `flags_o` unchanged.
- R8: `flags_o` ORs in new events until `ack_i` is high. The cycle after an acknowledge, `flags_o` is 0, or only the word of the events from that same cycle.
- R9: A tick while the channel is on and all enables are clear turns the channel off, leaves `cmp_o` unchanged and raises no event. Ticks while the channel is off are ignored.
- R10: `lost_o` accumulates lost interrupts and saturates at its maximum value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Comparator match pulse from the timer channel |
| count_i | input | COUNT_W | Current main counter value |
| upd_en_i | input | 1 | Update interrupt enable |
| alm_en_i | input | 1 | Alarm interrupt enable |
| per_en_i | input | 1 | Periodic interrupt enable |
| rate_i | input | 4 | Periodic rate code, rate = 2^code Hz |
| alm_hr_i | input | 5 | Alarm hours |
| alm_min_i | input | 6 | Alarm minutes |
| alm_sec_i | input | 6 | Alarm seconds |
| now_hr_i | input | 5 | Current hours |
| now_min_i | input | 6 | Current minutes |
| now_sec_i | input | 6 | Current seconds |
| ack_i | input | 1 | Acknowledge, clears the flag word |
| irq_o | output | 1 | One-cycle interrupt strobe |
| flags_o | output | 16 | Held interrupt flag word |
| chan_en_o | output | 1 | Timer channel enable |
| cmp_o | output | COUNT_W | Comparator value |
| lost_o | output | LOST_W | Saturating lost-interrupt total |

## Verification
Every result is due one cycle after the edge that samples its cause:
- a tick moves `cmp_o`, `lost_o`, `irq_o` and `flags_o` at that edge;
- the arming condition moves `chan_en_o` and `cmp_o` at that edge.

The bench drives inputs at the falling edge. It updates its arithmetic reference for that same rising edge, and compares all outputs at the next falling edge, so each result is sampled exactly one register stage after its stimulus.

Scenario checks count interrupt pulses over 64 on-time ticks for every rate code. They also measure comparator advance and loss for each catch-up gap, one cycle after the late tick.

// File: rtl/rtc_irq_emu_pkg.sv
package rtc_irq_emu_pkg;

    // base tick is 2^6 = 64 per second
    localparam int BASE_LOG2 = 6;
    localparam int CODE_LO   = 1;
    localparam int CODE_HI   = 13;

    // flag word bit positions, decoded by the consumer
    localparam int BIT_UPD  = 4;
    localparam int BIT_ALM  = 5;
    localparam int BIT_PER  = 6;
    localparam int BIT_PEND = 7;
    localparam int CNT_LSB  = 8;

    typedef struct packed {
        logic upd;
        logic alm;
        logic per;
    } evt_t;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } tod_t;

    function automatic logic [3:0] clamp_code(input logic [3:0] c);
        if (c < 4'(CODE_LO))      return 4'(CODE_LO);
        else if (c > 4'(CODE_HI)) return 4'(CODE_HI);
        else                      return c;
    endfunction

    // right shift applied to the base step for rates above the base
    function automatic logic [2:0] over_base(input logic [3:0] cc);
        if (cc > 4'(BASE_LOG2)) return 3'(cc - 4'(BASE_LOG2));
        else                    return 3'd0;
    endfunction

    // log2 of the divider limit for rates at or below the base
    function automatic logic [2:0] under_base(input logic [3:0] cc);
        if (cc < 4'(BASE_LOG2)) return 3'(4'(BASE_LOG2) - cc);
        else                    return 3'd0;
    endfunction

    function automatic logic [15:0] flag_word(input evt_t e);
        logic [15:0] w;
        w = '0;
        w[BIT_UPD]  = e.upd;
        w[BIT_ALM]  = e.alm;
        w[BIT_PER]  = e.per;
        w[BIT_PEND] = 1'b1;
        w[15:CNT_LSB] = 8'd1;
        return w;
    endfunction

endpackage

// File: rtl/rtc_irq_emu_catchup.sv
module rtc_irq_emu_catchup #(
    parameter int COUNT_W   = 32,
    parameter int MAX_CATCH = 8,
    localparam int LK_W     = $clog2(MAX_CATCH + 1)
) (
    input  logic [COUNT_W-1:0] cmp_cur,
    input  logic [COUNT_W-1:0] step,
    input  logic [COUNT_W-1:0] count,
    output logic [COUNT_W-1:0] cmp_next,
    output logic [LK_W-1:0]    lost
);

    logic [COUNT_W-1:0] cand   [0:MAX_CATCH];
    logic [MAX_CATCH:1] behind;

    assign cand[0] = cmp_cur;

    generate
        for (genvar k = 1; k <= MAX_CATCH; k++) begin : g_cand
            logic [COUNT_W-1:0] diff;
            assign cand[k]   = cand[k-1] + step;
            assign diff      = count - cand[k];
            assign behind[k] = ($signed(diff) > 0);
        end
    endgenerate

    always_comb begin
        logic found;
        found    = 1'b0;
        cmp_next = cand[MAX_CATCH];
        lost     = LK_W'(MAX_CATCH - 1);
        for (int k = 1; k <= MAX_CATCH; k++) begin
            if (!found && !behind[k]) begin
                found    = 1'b1;
                cmp_next = cand[k];
                lost     = LK_W'(k - 1);
            end
        end
    end

endmodule

// File: rtl/rtc_irq_emu_periodic.sv
module rtc_irq_emu_periodic
    import rtc_irq_emu_pkg::*;
#(
    parameter int MAX_CATCH = 8,
    localparam int LK_W     = $clog2(MAX_CATCH + 1),
    localparam int PC_W     = 7 + LK_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm,
    input  logic            go,
    input  logic [3:0]      code,
    input  logic [LK_W-1:0] lost,
    output logic            fire
);

    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] nxt;
    logic [PC_W-1:0] limit;

    assign nxt   = pcnt + PC_W'(1) + PC_W'(lost);
    assign limit = PC_W'(1) << under_base(code);
    assign fire  = go && (nxt >= limit);

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            pcnt <= '0;
        end else if (go) begin
            pcnt <= fire ? '0 : nxt;
        end
    end

endmodule

// File: rtl/rtc_irq_emu_update.sv
module rtc_irq_emu_update (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       go,
    input  logic [5:0] sec,
    output logic       fire
);

    logic       en_q;
    logic       valid;
    logic [5:0] prev;
    logic       rise;
    logic       eff_valid;
    logic       differs;

    assign rise      = en && !en_q;
    assign eff_valid = valid && !rise;
    assign differs   = !eff_valid || (sec != prev);
    assign fire      = go && en && eff_valid && (sec != prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            valid <= 1'b0;
            prev  <= '0;
        end else begin
            en_q <= en;
            if (go && en) begin
                if (differs) begin
                    prev  <= sec;
                    valid <= 1'b1;
                end else begin
                    valid <= eff_valid;
                end
            end else if (rise) begin
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu
    import rtc_irq_emu_pkg::*;
#(
    parameter int COUNT_W   = 32,
    parameter int BASE_STEP = 1024,
    parameter int MAX_CATCH = 8,
    parameter int LOST_W    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  logic [COUNT_W-1:0] count_i,
    input  logic               upd_en_i,
    input  logic               alm_en_i,
    input  logic               per_en_i,
    input  logic [3:0]         rate_i,
    input  logic [4:0]         alm_hr_i,
    input  logic [5:0]         alm_min_i,
    input  logic [5:0]         alm_sec_i,
    input  logic [4:0]         now_hr_i,
    input  logic [5:0]         now_min_i,
    input  logic [5:0]         now_sec_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [15:0]        flags_o,
    output logic               chan_en_o,
    output logic [COUNT_W-1:0] cmp_o,
    output logic [LOST_W-1:0]  lost_o
);

    localparam int LK_W = $clog2(MAX_CATCH + 1);
    localparam logic [COUNT_W-1:0] BASE_V = COUNT_W'(BASE_STEP);
    localparam logic [LOST_W:0]    LOST_MAX = {1'b0, {LOST_W{1'b1}}};

    logic               any_en;
    logic [3:0]         cc;
    logic [COUNT_W-1:0] step;
    logic               arm, go, off;
    logic [COUNT_W-1:0] cmp_nx;
    logic [LK_W-1:0]    lost_k;
    logic [LOST_W:0]    lost_sum;
    evt_t               ev;
    logic               ev_any;
    tod_t               now_t, alm_t;

    assign any_en = upd_en_i | alm_en_i | per_en_i;
    assign cc     = clamp_code(rate_i);
    assign step   = per_en_i ? (BASE_V >> over_base(cc)) : BASE_V;
    assign arm    = !chan_en_o && any_en;
    assign go     = tick_i && chan_en_o && any_en;
    assign off    = tick_i && chan_en_o && !any_en;

    rtc_irq_emu_catchup #(
        .COUNT_W  (COUNT_W),
        .MAX_CATCH(MAX_CATCH)
    ) u_catch (
        .cmp_cur (cmp_o),
        .step    (step),
        .count   (count_i),
        .cmp_next(cmp_nx),
        .lost    (lost_k)
    );

    rtc_irq_emu_periodic #(
        .MAX_CATCH(MAX_CATCH)
    ) u_per (
        .clk (clk),
        .rst (rst),
        .arm (arm),
        .go  (go && per_en_i),
        .code(cc),
        .lost(lost_k),
        .fire(ev.per)
    );

    rtc_irq_emu_update u_upd (
        .clk (clk),
        .rst (rst),
        .en  (upd_en_i),
        .go  (go),
        .sec (now_sec_i),
        .fire(ev.upd)
    );

    assign now_t  = '{hr: now_hr_i, mn: now_min_i, sc: now_sec_i};
    assign alm_t  = '{hr: alm_hr_i, mn: alm_min_i, sc: alm_sec_i};
    assign ev.alm = go && alm_en_i && (now_t == alm_t);
    assign ev_any = ev.upd | ev.alm | ev.per;

    assign lost_sum = {1'b0, lost_o} + (LOST_W + 1)'(lost_k);

    // channel enable and comparator
    always_ff @(posedge clk) begin
        if (rst) begin
            chan_en_o <= 1'b0;
            cmp_o     <= '0;
        end else if (arm) begin
            chan_en_o <= 1'b1;
            cmp_o     <= count_i + step;
        end else if (off) begin
            chan_en_o <= 1'b0;
        end else if (go) begin
            cmp_o <= cmp_nx;
        end
    end

    // saturating loss total
    always_ff @(posedge clk) begin
        if (rst) begin
            lost_o <= '0;
        end else if (go) begin
            lost_o <= (lost_sum > LOST_MAX) ? LOST_MAX[LOST_W-1:0] : lost_sum[LOST_W-1:0];
        end
    end

    // strobe and held flag word
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o   <= 1'b0;
            flags_o <= '0;
        end else begin
            irq_o <= ev_any;
            if (ack_i) begin
                flags_o <= ev_any ? flag_word(ev) : '0;
            end else if (ev_any) begin
                flags_o <= flags_o | flag_word(ev);
            end
        end
    end

endmodule

// File: rtl/rtc_irq_emu_chk.sv
module rtc_irq_emu_chk #(
    parameter int LOST_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              ack_i,
    input logic              upd_en_i,
    input logic              alm_en_i,
    input logic              per_en_i,
    input logic              irq_o,
    input logic [15:0]       flags_o,
    input logic              chan_en_o,
    input logic [LOST_W-1:0] lost_o
);

    assert_irq_word_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (flags_o[7] && flags_o[15:8] == 8'd1));

    assert_irq_after_tick_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(tick_i));

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!ack_i && flags_o != 16'd0) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    assert_ack_clear_R8: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> (flags_o == 16'd0 || irq_o));

    assert_arm_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(chan_en_o) |-> $past(upd_en_i || alm_en_i || per_en_i));

    assert_chan_off_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(chan_en_o) |-> $past(tick_i && !(upd_en_i || alm_en_i || per_en_i)));

    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        !chan_en_o |=> !irq_o);

    assert_lost_mono_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lost_o >= $past(lost_o)));

endmodule

bind rtc_irq_emu rtc_irq_emu_chk #(.LOST_W(LOST_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .ack_i    (ack_i),
    .upd_en_i (upd_en_i),
    .alm_en_i (alm_en_i),
    .per_en_i (per_en_i),
    .irq_o    (irq_o),
    .flags_o  (flags_o),
    .chan_en_o(chan_en_o),
    .lost_o   (lost_o)
);

// File: tb/rtc_irq_emu_test.sv
module rtc_irq_emu_test;

    localparam int CW   = 16;
    localparam int BASE = 128;
    localparam int MAXC = 4;
    localparam int LW   = 3;
    localparam int LMAX = (1 << LW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_i = 1'b0;
    logic [CW-1:0] count_i = '0;
    logic          upd_en_i = 1'b0, alm_en_i = 1'b0, per_en_i = 1'b0;
    logic [3:0]    rate_i = 4'd6;
    logic [4:0]    alm_hr_i = '0, now_hr_i = '0;
    logic [5:0]    alm_min_i = '0, alm_sec_i = '0, now_min_i = '0, now_sec_i = '0;
    logic          ack_i = 1'b0;
    logic          irq_o;
    logic [15:0]   flags_o;
    logic          chan_en_o;
    logic [CW-1:0] cmp_o;
    logic [LW-1:0] lost_o;

    always #5 clk = ~clk;

    rtc_irq_emu #(.COUNT_W(CW), .BASE_STEP(BASE), .MAX_CATCH(MAXC), .LOST_W(LW)) uut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .count_i(count_i),
        .upd_en_i(upd_en_i), .alm_en_i(alm_en_i), .per_en_i(per_en_i), .rate_i(rate_i),
        .alm_hr_i(alm_hr_i), .alm_min_i(alm_min_i), .alm_sec_i(alm_sec_i),
        .now_hr_i(now_hr_i), .now_min_i(now_min_i), .now_sec_i(now_sec_i),
        .ack_i(ack_i), .irq_o(irq_o), .flags_o(flags_o), .chan_en_o(chan_en_o),
        .cmp_o(cmp_o), .lost_o(lost_o)
    );

    int n_chk = 0, n_fail = 0, irq_seen = 0;
    bit done = 1'b0;

    // reference state
    int m_cmp = 0, m_pc = 0, m_prev = 0, m_lost = 0, m_flags = 0;
    bit m_chan = 0, m_valid = 0, m_uq = 0, m_irq = 0;

    task automatic check(string tag, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int clampc(int c);
        if (c < 1) return 1;
        if (c > 13) return 13;
        return c;
    endfunction

    function automatic int step_of(bit pe, int code);
        int cc = clampc(code);
        if (pe && cc > 6) return BASE * 64 / (1 << cc);
        return BASE;
    endfunction

    // advance reference by one edge with the current inputs, then compare
    task automatic cyc(string tag);
        bit any, go, rise;
        int stepv, ev, lostk, k, cand, diff, nx, lim, cc;
        any   = upd_en_i | alm_en_i | per_en_i;
        cc    = clampc(int'(rate_i));
        stepv = step_of(per_en_i, int'(rate_i));
        go    = tick_i && m_chan && any;
        rise  = upd_en_i && !m_uq;
        ev    = 0;
        lostk = 0;
        if (!m_chan && any) begin
            m_chan = 1; m_cmp = (int'(count_i) + stepv) & 16'hFFFF; m_pc = 0;
        end else if (tick_i && m_chan && !any) begin
            m_chan = 0;
        end else if (go) begin
            k = MAXC;
            for (int j = MAXC; j >= 1; j--) begin
                cand = (m_cmp + j * stepv) & 16'hFFFF;
                diff = (int'(count_i) - cand) & 16'hFFFF;
                if (!(diff != 0 && diff < 32768)) k = j;
            end
            lostk  = k - 1;
            m_cmp  = (m_cmp + k * stepv) & 16'hFFFF;
            m_lost = (m_lost + lostk > LMAX) ? LMAX : m_lost + lostk;
            if (per_en_i) begin
                nx  = m_pc + 1 + lostk;
                lim = (cc <= 6) ? 64 / (1 << cc) : 1;
                if (nx >= lim) begin ev |= 16'h0040; m_pc = 0; end
                else m_pc = nx;
            end
            if (alm_en_i && now_hr_i == alm_hr_i && now_min_i == alm_min_i
                && now_sec_i == alm_sec_i) ev |= 16'h0020;
        end
        if (go && upd_en_i) begin
            if (m_valid && !rise && int'(now_sec_i) != m_prev) ev |= 16'h0010;
            if (!(m_valid && !rise) || int'(now_sec_i) != m_prev) begin
                m_prev = int'(now_sec_i); m_valid = 1;
            end else m_valid = m_valid && !rise;
        end else if (rise) m_valid = 0;
        m_uq = upd_en_i;
        if (ev != 0) ev |= 16'h0180;
        if (ack_i) m_flags = ev;
        else m_flags |= ev;
        m_irq = (ev != 0);
        @(posedge clk);
        @(negedge clk);
        if (irq_o) irq_seen++;
        check(tag, "irq_o", int'(irq_o), int'(m_irq));
        check(tag, "flags_o", int'(flags_o), m_flags);
        check(tag, "chan_en_o", int'(chan_en_o), int'(m_chan));
        check(tag, "cmp_o", int'(cmp_o), m_cmp);
        check(tag, "lost_o", int'(lost_o), m_lost);
    endtask

    task automatic tick_at(string tag, int cnt);
        count_i = CW'(cnt);
        tick_i  = 1'b1;
        cyc(tag);
        tick_i  = 1'b0;
        cyc(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c0, l0, irq0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "irq_o", int'(irq_o), 0);
        check("R1", "flags_o", int'(flags_o), 0);
        check("R1", "chan_en_o", int'(chan_en_o), 0);
        check("R1", "cmp_o", int'(cmp_o), 0);
        check("R1", "lost_o", int'(lost_o), 0);

        // R9 tick while off is ignored
        tick_at("R9", 0);

        // R2 arming: code 6, step BASE
        count_i = 16'd100; per_en_i = 1'b1; rate_i = 4'd6;
        cyc("R2");
        check("R2", "armed cmp", int'(cmp_o), 100 + BASE);
        check("R2", "armed chan", int'(chan_en_o), 1);

        // R6 periodic sweep over all codes, 64 on-time ticks each
        ack_i = 1'b1;
        for (int code = 0; code < 16; code++) begin
            per_en_i = 1'b0;
            tick_at("R9", m_cmp);
            check("R9", "channel dropped", int'(chan_en_o), 0);
            per_en_i = 1'b1; rate_i = 4'(code);
            count_i = 16'd1000;
            cyc("R2");
            check("R2", "arm step", int'(cmp_o), 1000 + step_of(1'b1, code));
            irq0 = irq_seen;
            for (int t = 0; t < 64; t++) tick_at("R6", m_cmp);
            check("R6", "periodic pulses in 64 ticks", irq_seen - irq0,
                  (clampc(code) <= 6) ? (1 << clampc(code)) : 64);
        end
        ack_i = 1'b0;

        // R3 catch-up gaps, R10 saturation
        rate_i = 4'd6;
        for (int g = 0; g <= MAXC + 1; g++) begin
            c0 = int'(cmp_o); l0 = int'(lost_o);
            count_i = CW'(c0 + g * BASE + 5);
            tick_i = 1'b1;
            cyc("R3");
            tick_i = 1'b0;
            check("R3", "advance", (int'(cmp_o) - c0) & 16'hFFFF,
                  ((g + 1 > MAXC) ? MAXC : g + 1) * BASE);
            check("R10", "lost total", int'(lost_o),
                  (l0 + ((g > MAXC - 1) ? MAXC - 1 : g) > LMAX) ? LMAX
                  : l0 + ((g > MAXC - 1) ? MAXC - 1 : g));
            ack_i = 1'b1; cyc("R8"); ack_i = 1'b0;
        end
        check("R10", "saturated", int'(lost_o), LMAX);

        // R4 update flag with suppression of first record
        per_en_i = 1'b0; upd_en_i = 1'b1;
        cyc("R4");
        now_sec_i = 6'd5; tick_at("R4", m_cmp);
        check("R4", "first record suppressed", int'(flags_o), 0);
        tick_at("R4", m_cmp);
        check("R4", "same second no flag", int'(flags_o), 0);
        now_sec_i = 6'd6; tick_at("R4", m_cmp);
        check("R4", "second change flag", int'(flags_o), 16'h0190);
        ack_i = 1'b1; cyc("R8"); ack_i = 1'b0;
        check("R8", "ack clears", int'(flags_o), 0);
        upd_en_i = 1'b0; cyc("R4");
        upd_en_i = 1'b1;
        now_sec_i = 6'd7; tick_at("R4", m_cmp);
        check("R4", "re-enable suppressed", int'(flags_o), 0);

        // R5 alarm and R8 accumulation
        alm_en_i = 1'b1; alm_hr_i = 5'd12; alm_min_i = 6'd34; alm_sec_i = 6'd56;
        now_hr_i = 5'd12; now_min_i = 6'd34; now_sec_i = 6'd55;
        tick_at("R5", m_cmp);
        check("R5", "near miss plus update", int'(flags_o), 16'h0190);
        now_sec_i = 6'd56;
        tick_at("R5", m_cmp);
        check("R5", "alarm accumulates", int'(flags_o), 16'h01B0);
        now_min_i = 6'd35;
        tick_at("R5", m_cmp);
        check("R7", "no event keeps word", int'(flags_o), 16'h01B0);
        check("R7", "no event no irq", int'(irq_o), 0);
        ack_i = 1'b1; cyc("R8"); ack_i = 1'b0;
        now_min_i = 6'd34;
        ack_i = 1'b1; count_i = CW'(m_cmp); tick_i = 1'b1;
        cyc("R8"); tick_i = 1'b0; ack_i = 1'b0;
        check("R8", "ack with same-cycle alarm", int'(flags_o), 16'h01A0);

        // R9 all-off tick then ignored ticks
        upd_en_i = 1'b0; alm_en_i = 1'b0;
        c0 = int'(cmp_o);
        tick_at("R9", m_cmp);
        check("R9", "cmp kept", int'(cmp_o), c0);
        tick_at("R9", c0 + 3 * BASE);
        check("R9", "still off", int'(chan_en_o), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule